// File: doc/BRIEF.md
# Pulse and Quadrature Counter

This block counts events arriving on two already-synchronized input lines, S0 and S1, inside one slow clock domain. It has four modes. It can count single-line edges of S0 with a two-sample stability check. It can count every sampled S0 edge. It can decode S0/S1 as a quadrature pair. In the off mode the count is frozen.

The count runs between zero and a programmable limit register (the limit). Counting up past the limit wraps to zero. Counting down below zero reloads the limit. A separately written shadow register feeds the limit in two cases: on an explicit load command, and automatically on every upward wrap. A second command preloads the counter from the limit.

An asynchronous clear input zeroes both the counter and the limit for as long as it is held. Overflow, underflow and direction-change events are reported as one-cycle pulses.

Top module: `pulse_quad_counter`

## Requirements
- R1: After `rst_n` is released, `count` is 0, `top_val` and the shadow register are all ones, and all three event pulses are 0.
- R2: While `cnt_clr` is high, `count` and `top_val` read 0 without waiting for a clock edge, and commands and inputs have no effect on them; the shadow register keeps its value.
- R3: `ld_top` copies the shadow value held before the edge into `top_val`. `ld_cnt` copies the `top_val` held before the edge into `count`. When either command is present, no counting takes place in that cycle. `topb_wr` writes `topb_wdata` into the shadow register.
- R4: With `mode_sel`=2 (per-sample edge mode), each selected S0 edge (`edge_fall`=0 rising, 1 falling) moves the count by one at the first clock edge that samples the new S0 level.
- R5: With `mode_sel`=1 (filtered edge mode), a selected S0 edge counts only at the second consecutive clock edge that samples the new level. A level that lasts a single sample is not counted.
- R6: In the two single-line modes, the count runs up when `dir_down`=0 and down when `dir_down`=1. When `s1_sets_dir`=1, the S1 level picks the direction instead (1 = down) and `dir_down` is ignored.
- R7: A step up taken while `count` >= `top_val` sets `count` to 0, loads the shadow value into `top_val`, and raises `ovf_evt` for one cycle.
- R8: A step down taken while `count` = 0 sets `count` to `top_val`, leaves `top_val` unchanged, and raises `unf_evt` for one cycle.
- R9: With `mode_sel`=3, the pair {S0,S1} steps up along 00→10→11→01→00 and steps down along the reverse order, one count per transition. A change of both bits, or no change, does not count. `dir_down` and `s1_sets_dir` are ignored in this mode.
- R10: In quadrature mode, `dirchg_evt` pulses for one cycle on a counted step whose direction differs from the previous counted quadrature step. The direction before the first step is up.
- R11: With `mode_sel`=0, S0/S1 activity leaves `count` unchanged, while `ld_top`, `ld_cnt` and `topb_wr` still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_clr | input | 1 | Asynchronous clear of count and limit while high |
| s0_in | input | 1 | Count input / quadrature phase A |
| s1_in | input | 1 | Direction input / quadrature phase B |
| mode_sel | input | 2 | 0 off, 1 filtered edge, 2 per-sample edge, 3 quadrature |
| edge_fall | input | 1 | 0 counts rising S0 edges, 1 counts falling edges |
| dir_down | input | 1 | Count direction in single-line modes, 1 = down |
| s1_sets_dir | input | 1 | Let the S1 level choose the direction in single-line modes |
| topb_wr | input | 1 | Write strobe for the shadow register |
| topb_wdata | input | CNT_W | Shadow register write data |
| ld_top | input | 1 | Command: shadow register to limit |
| ld_cnt | input | 1 | Command: limit to count |
| count | output | CNT_W | Counter value |
| top_val | output | CNT_W | Current limit |
| ovf_evt | output | 1 | Overflow pulse |
| unf_evt | output | 1 | Underflow pulse |
| dirchg_evt | output | 1 | Quadrature direction-change pulse |

## Verification
The bench builds the block with `CNT_W`=4, so the reset limit is 15. With limits of 9, 5 and 3, many upward and downward wraps happen within a few dozen pulses, including a shadow reload that shrinks the limit at the moment of a wrap. In quadrature mode the bench sweeps all sixteen previous/current {S0,S1} pairs, which covers every legal step, every double-bit jump and every direction reversal. Single-sample and two-sample pulses exercise the filter in the filtered edge mode on both edge polarities.

// File: rtl/pqc_pkg.sv
package pqc_pkg;

  typedef enum logic [1:0] {
    PQC_OFF  = 2'd0,
    PQC_FILT = 2'd1,
    PQC_EDGE = 2'd2,
    PQC_QUAD = 2'd3
  } pqc_mode_e;

  // Next {S0,S1} state when stepping forward (up).
  function automatic logic [1:0] quad_fwd(input logic [1:0] ab);
    case (ab)
      2'b00:   quad_fwd = 2'b10;
      2'b10:   quad_fwd = 2'b11;
      2'b11:   quad_fwd = 2'b01;
      default: quad_fwd = 2'b00;
    endcase
  endfunction

  // Next {S0,S1} state when stepping backward (down).
  function automatic logic [1:0] quad_rev(input logic [1:0] ab);
    case (ab)
      2'b00:   quad_rev = 2'b01;
      2'b01:   quad_rev = 2'b11;
      2'b11:   quad_rev = 2'b10;
      default: quad_rev = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/pqc_input_decode.sv
module pqc_input_decode
  import pqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      s0,
  input  logic      s1,
  input  pqc_mode_e mode,
  input  logic      edge_fall,
  input  logic      dir_down,
  input  logic      s1_sets_dir,
  output logic      step,
  output logic      step_down,
  output logic      quad_step
);

  logic       s0_h1, s0_h2;
  logic [1:0] q_prev;
  logic [1:0] q_cur;
  logic       edge_ev, filt_ev, q_up, q_dn, single_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_h1  <= 1'b0;
      s0_h2  <= 1'b0;
      q_prev <= 2'b00;
    end else begin
      s0_h1  <= s0;
      s0_h2  <= s0_h1;
      q_prev <= q_cur;
    end
  end

  assign q_cur       = {s0, s1};
  assign edge_ev     = edge_fall ? (!s0 && s0_h1) : (s0 && !s0_h1);
  assign filt_ev     = edge_fall ? (!s0 && !s0_h1 && s0_h2) : (s0 && s0_h1 && !s0_h2);
  assign q_up        = (q_cur == quad_fwd(q_prev));
  assign q_dn        = (q_cur == quad_rev(q_prev));
  assign single_down = s1_sets_dir ? s1 : dir_down;

  always_comb begin
    step      = 1'b0;
    step_down = 1'b0;
    quad_step = 1'b0;
    case (mode)
      PQC_FILT: begin
        step      = filt_ev;
        step_down = single_down;
      end
      PQC_EDGE: begin
        step      = edge_ev;
        step_down = single_down;
      end
      PQC_QUAD: begin
        step      = q_up || q_dn;
        step_down = q_dn;
        quad_step = q_up || q_dn;
      end
      default: ;
    endcase
  end

  // R9: a double-bit jump never yields a step
  p_quad_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PQC_QUAD && (q_cur ^ q_prev) == 2'b11) |-> !step);

  // R9: an unchanged pair never yields a step
  p_quad_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PQC_QUAD && q_cur == q_prev) |-> !step);

endmodule

// File: rtl/pqc_count_regs.sv
module pqc_count_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             step_down,
  input  logic             quad_step,
  input  logic             ld_top,
  input  logic             ld_cnt,
  input  logic             topb_wr,
  input  logic [CNT_W-1:0] topb_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top,
  output logic             ovf,
  output logic             unf,
  output logic             dirchg
);

  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO = '0;

  function automatic logic [CNT_W-1:0] step_val(input logic [CNT_W-1:0] c,
                                                input logic dn);
    step_val = dn ? c - 1'b1 : c + 1'b1;
  endfunction

  logic [CNT_W-1:0] topb;
  logic             last_down;
  logic             ld_any, step_eff, wrap_up, wrap_dn;
  logic [CNT_W-1:0] cnt_next;

  assign ld_any   = ld_top || ld_cnt;
  assign step_eff = step && !ld_any && !clr;
  assign wrap_up  = step_eff && !step_down && (cnt >= top);
  assign wrap_dn  = step_eff && step_down && (cnt == ZERO);
  assign cnt_next = step_val(cnt, step_down);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) topb <= ONES;
    else if (topb_wr) topb <= topb_wdata;
  end

  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n) begin
      cnt <= ZERO;
      top <= ONES;
    end else if (clr) begin
      cnt <= ZERO;
      top <= ZERO;
    end else if (ld_any) begin
      if (ld_cnt) cnt <= top;
      if (ld_top) top <= topb;
    end else if (wrap_up) begin
      cnt <= ZERO;
      top <= topb;
    end else if (wrap_dn) begin
      cnt <= top;
    end else if (step_eff) begin
      cnt <= cnt_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf       <= 1'b0;
      unf       <= 1'b0;
      dirchg    <= 1'b0;
      last_down <= 1'b0;
    end else begin
      ovf    <= wrap_up;
      unf    <= wrap_dn;
      dirchg <= step_eff && quad_step && (step_down != last_down);
      if (step_eff && quad_step) last_down <= step_down;
    end
  end

  // R2: held clear keeps count and limit at zero
  p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (cnt == ZERO && top == ZERO));

  // R7: overflow pulse coincides with a zero count
  p_ovf_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ovf |-> cnt == ZERO);

  // R8: underflow pulse coincides with count equal to the limit
  p_unf_top_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    unf |-> cnt == top);

  // R7: the two wrap pulses are exclusive
  p_wrap_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  // R3: limit load takes the shadow value present before the edge
  p_ld_top_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ld_top |=> top == $past(topb));

  // R3: count load takes the limit present before the edge
  p_ld_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ld_cnt |=> cnt == $past(top));

endmodule

// File: rtl/pulse_quad_counter.sv
module pulse_quad_counter
  import pqc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clr,
  input  logic             s0_in,
  input  logic             s1_in,
  input  logic [1:0]       mode_sel,
  input  logic             edge_fall,
  input  logic             dir_down,
  input  logic             s1_sets_dir,
  input  logic             topb_wr,
  input  logic [CNT_W-1:0] topb_wdata,
  input  logic             ld_top,
  input  logic             ld_cnt,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] top_val,
  output logic             ovf_evt,
  output logic             unf_evt,
  output logic             dirchg_evt
);

  pqc_mode_e mode;
  logic      dec_step, dec_down, dec_quad;

  assign mode = pqc_mode_e'(mode_sel);

  pqc_input_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .s0          (s0_in),
    .s1          (s1_in),
    .mode        (mode),
    .edge_fall   (edge_fall),
    .dir_down    (dir_down),
    .s1_sets_dir (s1_sets_dir),
    .step        (dec_step),
    .step_down   (dec_down),
    .quad_step   (dec_quad)
  );

  pqc_count_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cnt_clr),
    .step       (dec_step),
    .step_down  (dec_down),
    .quad_step  (dec_quad),
    .ld_top     (ld_top),
    .ld_cnt     (ld_cnt),
    .topb_wr    (topb_wr),
    .topb_wdata (topb_wdata),
    .cnt        (count),
    .top        (top_val),
    .ovf        (ovf_evt),
    .unf        (unf_evt),
    .dirchg     (dirchg_evt)
  );

  // R11: off mode without a count load leaves the count unchanged
  p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || cnt_clr)
    (mode_sel == 2'd0 && !ld_cnt) |=> $stable(count));

  // R10: a direction change is only reported in quadrature mode
  p_dirchg_quad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'd3) |=> !dirchg_evt);

endmodule

// File: tb/tb_pulse_quad_counter.sv
module tb_pulse_quad_counter;
  localparam int W   = 4;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0, cnt_clr = 0, s0 = 0, s1 = 0;
  logic [1:0] mode_sel = 0;
  logic edge_fall = 0, dir_down = 0, s1_sets_dir = 0;
  logic topb_wr = 0, ld_top = 0, ld_cnt = 0;
  logic [W-1:0] topb_wdata = 0;
  logic [W-1:0] count, top_val;
  logic ovf_evt, unf_evt, dirchg_evt;

  always #(PER/2) clk = ~clk;

  pulse_quad_counter #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .s0_in(s0), .s1_in(s1),
    .mode_sel(mode_sel), .edge_fall(edge_fall), .dir_down(dir_down),
    .s1_sets_dir(s1_sets_dir), .topb_wr(topb_wr), .topb_wdata(topb_wdata),
    .ld_top(ld_top), .ld_cnt(ld_cnt), .count(count), .top_val(top_val),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt), .dirchg_evt(dirchg_evt)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // expected state
  int e_cnt = 0, e_top = 15, e_topb = 15;
  bit h1 = 0, h2 = 0, e_last_dn = 0;
  bit [1:0] qp = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gidx(input bit [1:0] ab);
    case (ab)
      2'b00: gidx = 0;
      2'b10: gidx = 1;
      2'b11: gidx = 2;
      default: gidx = 3;
    endcase
  endfunction

  task automatic cyc(input bit a0, input bit a1, input string tag);
    bit ev, dn, qs, x_ovf, x_unf, x_dc;
    int nc, nt, d;
    ev = 0; dn = 0; qs = 0; x_ovf = 0; x_unf = 0; x_dc = 0;
    s0 = a0; s1 = a1;
    case (mode_sel)
      2'd1: begin
        ev = edge_fall ? (!a0 && !h1 && h2) : (a0 && h1 && !h2);
        dn = s1_sets_dir ? a1 : dir_down;
      end
      2'd2: begin
        ev = edge_fall ? (!a0 && h1) : (a0 && !h1);
        dn = s1_sets_dir ? a1 : dir_down;
      end
      2'd3: begin
        d = (gidx({a0, a1}) - gidx(qp) + 4) % 4;
        if (d == 1) begin ev = 1; dn = 0; end
        if (d == 3) begin ev = 1; dn = 1; end
        qs = ev;
      end
      default: ;
    endcase
    nc = e_cnt; nt = e_top;
    if (ld_top || ld_cnt) begin
      if (ld_cnt) nc = e_top;
      if (ld_top) nt = e_topb;
    end else if (ev) begin
      if (!dn) begin
        if (e_cnt >= e_top) begin nc = 0; nt = e_topb; x_ovf = 1; end
        else nc = e_cnt + 1;
      end else begin
        if (e_cnt == 0) begin nc = e_top; x_unf = 1; end
        else nc = e_cnt - 1;
      end
      if (qs) begin x_dc = (dn != e_last_dn); e_last_dn = dn; end
    end
    if (topb_wr) e_topb = topb_wdata;
    e_cnt = nc; e_top = nt;
    h2 = h1; h1 = a0; qp = {a0, a1};
    @(posedge clk); #2;
    ld_top = 0; ld_cnt = 0; topb_wr = 0;
    chk({tag, " count"}, count, e_cnt);
    chk({tag, " limit"}, top_val, e_top);
    chk("R7 ovf", ovf_evt, x_ovf);
    chk("R8 unf", unf_evt, x_unf);
    chk("R10 dirchg", dirchg_evt, x_dc);
  endtask

  task automatic pulses(input int n, input bit lvl1, input string tag);
    for (int i = 0; i < n; i++) begin
      cyc(1, lvl1, tag);
      cyc(0, lvl1, tag);
    end
  endtask

  initial begin
    #(PER * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(PER * 2 + 3);
    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 limit", top_val, 15);
    chk("R1 ovf", ovf_evt, 0);
    chk("R1 unf", unf_evt, 0);
    chk("R1 dirchg", dirchg_evt, 0);
    rst_n = 1;
    @(posedge clk); #2;

    // R3: buffered limit and count preload
    topb_wr = 1; topb_wdata = 9; cyc(0, 0, "R3");
    ld_top = 1; cyc(0, 0, "R3");
    ld_cnt = 1; cyc(0, 0, "R3");
    topb_wr = 1; topb_wdata = 5; cyc(0, 0, "R3");
    ld_top = 1; cyc(0, 0, "R3");
    topb_wr = 1; topb_wdata = 12; cyc(0, 0, "R3");
    ld_top = 1; ld_cnt = 1; cyc(0, 0, "R3");
    // command overrides a count in the same cycle
    mode_sel = 2; ld_cnt = 1; cyc(1, 0, "R3"); cyc(0, 0, "R3");
    mode_sel = 0;

    // R2: asynchronous clear
    #3; cnt_clr = 1; #1;
    chk("R2 count", count, 0);
    chk("R2 limit", top_val, 0);
    ld_top = 1;
    @(posedge clk); #2;
    chk("R2 count held", count, 0);
    chk("R2 limit held", top_val, 0);
    h2 = h1; h1 = s0; qp = {s0, s1};
    e_cnt = 0; e_top = 0;
    cnt_clr = 0; ld_top = 0;
    // shadow survived the clear: load it back
    ld_top = 1; cyc(0, 0, "R2");
    topb_wr = 1; topb_wdata = 9; cyc(0, 0, "R2");
    ld_top = 1; cyc(0, 0, "R2");

    // R4: per-sample edge mode, rising then falling
    mode_sel = 2;
    pulses(23, 0, "R4");
    edge_fall = 1;
    pulses(12, 0, "R4");
    edge_fall = 0;

    // R7: shadow reload on wrap shrinks the limit
    topb_wr = 1; topb_wdata = 3; cyc(0, 0, "R7");
    pulses(16, 0, "R7");

    // R8: down counting through zero
    dir_down = 1;
    pulses(14, 0, "R8");

    // R6: S1 picks the direction
    s1_sets_dir = 1; dir_down = 0;
    pulses(7, 1, "R6");
    dir_down = 1;
    pulses(9, 0, "R6");
    s1_sets_dir = 0; dir_down = 0;

    // R5: filtered edge mode
    mode_sel = 1;
    for (int i = 0; i < 5; i++) begin
      cyc(1, 0, "R5"); cyc(0, 0, "R5"); cyc(0, 0, "R5");
    end
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, "R5"); cyc(1, 0, "R5"); cyc(0, 0, "R5"); cyc(0, 0, "R5");
    end
    edge_fall = 1;
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, "R5"); cyc(1, 0, "R5"); cyc(0, 0, "R5"); cyc(1, 0, "R5");
    end
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, "R5"); cyc(0, 0, "R5"); cyc(0, 0, "R5"); cyc(1, 0, "R5");
    end
    edge_fall = 0;

    // R11: off mode holds, commands still work
    mode_sel = 0;
    pulses(6, 0, "R11");
    cyc(1, 1, "R11"); cyc(0, 1, "R11");
    topb_wr = 1; topb_wdata = 11; cyc(0, 0, "R11");
    ld_top = 1; cyc(0, 0, "R11");
    ld_cnt = 1; cyc(0, 0, "R11");

    // R9, R10: quadrature, exhaustive pair sweep
    mode_sel = 3; dir_down = 1; s1_sets_dir = 1;
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 4; c++) begin
        cyc(p[1], p[0], "R9");
        cyc(c[1], c[0], "R9");
      end
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, "R9"); cyc(1, 0, "R9"); cyc(1, 1, "R9"); cyc(0, 1, "R9");
    end
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, "R9"); cyc(0, 1, "R9"); cyc(1, 1, "R9"); cyc(1, 0, "R9");
    end
    cyc(1, 1, "R10"); cyc(1, 0, "R10"); cyc(1, 1, "R10");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule